// File: doc/BRIEF.md
# Branch and Skip Condition Unit

This unit resolves the program-counter outcome of a 16-bit processor's conditional control instructions. One evaluation covers either a conditional branch or one of six skip operations. The caller supplies the current program counter, an accumulator operand, a memory operand, an 8-bit signed displacement or immediate, a 4-bit condition selector, the carry, overflow and link flags, and three external jump-condition pins. The unit returns the next program counter, a flag that says whether the branch or skip was taken, and, for the counting operations, a value to write back.

A branch adds the sign-extended displacement to the program counter when its selected condition holds. A skip sets the program counter to PC+1, which steps over the next instruction word. The compare skips test the accumulator against the memory operand. The counting skips change a word and skip when the new value is zero. All program-counter arithmetic wraps modulo 2^16.

Each evaluation is exchanged through a valid/ready pair on the input side and another on the output side. Operands are captured when the unit accepts a request. The result is held until the consumer takes it.

Top module: `branch_skip_unit`

## Requirements
- R1: After reset `inReady` is 1. A request is accepted on a rising edge where `inValid` and `inReady` are both 1. From the next cycle `outValid` is 1 and `inReady` is 0, until an edge where `outValid` and `outReady` are both 1. After that edge `outValid` is 0 and `inReady` is 1.
- R2: While `outValid` is 1 and `outReady` is 0, `outValid`, `nextPc`, `taken`, `wbValid` and `wbData` stay stable, even if the request inputs change.
- R3: For `opSel`=0 (branch) with a true condition, `taken`=1 and `nextPc` = `pcIn` + sign-extended `immIn`, modulo 2^16.
- R4: For a branch with a false condition, and for any skip whose test fails, `taken`=0 and `nextPc`=`pcIn`.
- R5: `condCode` selects the branch condition as follows. 0 is always true. 1: `accIn`==0. 2: `accIn`[15]=1. 3: `accIn`!=0. 4: carry. 5: overflow. 6: link. 7: `accIn`[15]=0. 8 to 12 are always false. 13, 14 and 15 are `extCond`[0], [1] and [2].
- R6: `opSel`=1 (not-equal skip) skips when `accIn` != `memIn`.
- R7: `opSel`=2 (greater skip) skips when `accIn` is greater than `memIn` as two's-complement signed numbers.
- R8: `opSel`=3 (AND-zero skip) skips when (`accIn` & `memIn`) == 0.
- R9: `opSel`=4 (increment) and `opSel`=5 (decrement) set `wbData` to `memIn`+1 or `memIn`-1 modulo 2^16, assert `wbValid`, and skip when that value is 0.
- R10: `opSel`=6 (add-immediate) sets `wbData` = `accIn` + sign-extended `immIn`, asserts `wbValid`, and skips when the sum is 0.
- R11: A taken skip sets `nextPc` = `pcIn`+1 modulo 2^16, so 0xFFFF becomes 0x0000.
- R12: `wbValid` is 1 only while `outValid` is 1 and `opSel` is 4, 5 or 6. `opSel`=7 is a no-op: `taken`=0, `nextPc`=`pcIn`, and no write-back.
- R13: During and just after reset, `outValid`=0 and `wbValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Unit can accept a request |
| opSel | input | 3 | Operation: 0 branch, 1 ne-skip, 2 gt-skip, 3 and-zero skip, 4 increment, 5 decrement, 6 add-immediate, 7 no-op |
| pcIn | input | 16 | Current program counter |
| accIn | input | 16 | Accumulator operand |
| memIn | input | 16 | Memory operand |
| immIn | input | 8 | Signed displacement or immediate |
| condCode | input | 4 | Branch condition selector |
| carryIn | input | 1 | Carry flag |
| ovfIn | input | 1 | Overflow flag |
| linkIn | input | 1 | Link flag |
| extCond | input | 3 | External jump-condition pins |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| nextPc | output | 16 | Resolved program counter |
| taken | output | 1 | Branch or skip taken |
| wbValid | output | 1 | `wbData` must be written back |
| wbData | output | 16 | Write-back value |

## Verification
The bench checks the wrap cases. A forward displacement crossing 0xFFFF, a negative displacement, a skip from 0xFFFF, an increment of 0xFFFF and a decrement of 0 each show whether the unit truncates to 16 bits or drops the sign extension of the 8-bit field. The greater skip is driven with operands whose order flips between a signed and an unsigned compare, so an unsigned comparator gives the wrong answer. All sixteen condition codes are run under two complementary flag and pin patterns. This catches a swapped pin index, a reserved code that reads as true, or a flag routed to the wrong slot. Every result is also held back for one cycle while the request inputs change, which exposes a datapath that reads live inputs instead of captured operands.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [2:0] {
    OP_BRANCH = 3'd0,
    OP_SKNE   = 3'd1,
    OP_SKG    = 3'd2,
    OP_SKAZ   = 3'd3,
    OP_ISZ    = 3'd4,
    OP_DSZ    = 3'd5,
    OP_AISZ   = 3'd6,
    OP_NONE   = 3'd7
  } bsuOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the request operands this cycle
    logic busy;     // a result is being presented
  } ctrlStrobe_t;

  localparam int COND_SLOTS = 16;

endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);

  logic busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (!busyQ && inValid) begin
      busyQ <= 1'b1;
    end else if (busyQ && outReady) begin
      busyQ <= 1'b0;
    end
  end

  assign inReady        = !busyQ;
  assign outValid       = busyQ;
  assign strobe.capture = !busyQ && inValid;
  assign strobe.busy    = busyQ;

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid && !inReady)); // R1

  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (!outValid && inReady)); // R1

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid); // R2

endmodule

// File: rtl/bsu_cond_select.sv
module bsu_cond_select
  import bsu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int NUM_EXT = 3
) (
  input  logic [3:0]         condCode,
  input  logic [WIDTH-1:0]   accVal,
  input  logic               carryFlag,
  input  logic               ovfFlag,
  input  logic               linkFlag,
  input  logic [NUM_EXT-1:0] extPins,
  output logic               condTrue
);

  localparam int EXT_BASE = COND_SLOTS - NUM_EXT;

  logic [COND_SLOTS-1:0] condVec;
  logic                  accZero;

  assign accZero = (accVal == '0);

  always_comb begin
    condVec    = '0;           // reserved slots read false
    condVec[0] = 1'b1;
    condVec[1] = accZero;
    condVec[2] = accVal[WIDTH-1];
    condVec[3] = !accZero;
    condVec[4] = carryFlag;
    condVec[5] = ovfFlag;
    condVec[6] = linkFlag;
    condVec[7] = !accVal[WIDTH-1];
    for (int i = 0; i < NUM_EXT; i++) begin
      condVec[EXT_BASE + i] = extPins[i];
    end
  end

  assign condTrue = condVec[condCode];

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int DISP_W  = 8,
  parameter int NUM_EXT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [2:0]         opIn,
  input  logic [WIDTH-1:0]   pcIn,
  input  logic [WIDTH-1:0]   accIn,
  input  logic [WIDTH-1:0]   memIn,
  input  logic [DISP_W-1:0]  immIn,
  input  logic [3:0]         condIn,
  input  logic               carryIn,
  input  logic               ovfIn,
  input  logic               linkIn,
  input  logic [NUM_EXT-1:0] extIn,
  output logic [WIDTH-1:0]   nextPc,
  output logic               taken,
  output logic               wbEn,
  output logic [WIDTH-1:0]   wbData
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  bsuOp_e             opQ;
  logic [WIDTH-1:0]   pcQ, accQ, memQ;
  logic [DISP_W-1:0]  immQ;
  logic [3:0]         condQ;
  logic               carryQ, ovfQ, linkQ;
  logic [NUM_EXT-1:0] extQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ    <= OP_NONE;
      pcQ    <= '0;
      accQ   <= '0;
      memQ   <= '0;
      immQ   <= '0;
      condQ  <= '0;
      carryQ <= 1'b0;
      ovfQ   <= 1'b0;
      linkQ  <= 1'b0;
      extQ   <= '0;
    end else if (strobe.capture) begin
      opQ    <= bsuOp_e'(opIn);
      pcQ    <= pcIn;
      accQ   <= accIn;
      memQ   <= memIn;
      immQ   <= immIn;
      condQ  <= condIn;
      carryQ <= carryIn;
      ovfQ   <= ovfIn;
      linkQ  <= linkIn;
      extQ   <= extIn;
    end
  end

  logic             condTrue;
  logic [WIDTH-1:0] immExt, incVal, decVal, addVal, branchPc, skipPc;
  logic             takeRaw;

  bsu_cond_select #(.WIDTH(WIDTH), .NUM_EXT(NUM_EXT)) uCond (
    .condCode (condQ),
    .accVal   (accQ),
    .carryFlag(carryQ),
    .ovfFlag  (ovfQ),
    .linkFlag (linkQ),
    .extPins  (extQ),
    .condTrue (condTrue)
  );

  assign immExt   = {{(WIDTH-DISP_W){immQ[DISP_W-1]}}, immQ};
  assign incVal   = memQ + ONE;
  assign decVal   = memQ - ONE;
  assign addVal   = accQ + immExt;
  assign branchPc = pcQ + immExt;
  assign skipPc   = pcQ + ONE;

  always_comb begin
    takeRaw = 1'b0;
    wbEn    = 1'b0;
    wbData  = '0;
    unique case (opQ)
      OP_BRANCH: takeRaw = condTrue;
      OP_SKNE:   takeRaw = (accQ != memQ);
      OP_SKG:    takeRaw = ($signed(accQ) > $signed(memQ));
      OP_SKAZ:   takeRaw = ((accQ & memQ) == '0);
      OP_ISZ: begin
        wbEn    = 1'b1;
        wbData  = incVal;
        takeRaw = (incVal == '0);
      end
      OP_DSZ: begin
        wbEn    = 1'b1;
        wbData  = decVal;
        takeRaw = (decVal == '0);
      end
      OP_AISZ: begin
        wbEn    = 1'b1;
        wbData  = addVal;
        takeRaw = (addVal == '0);
      end
      OP_NONE:   takeRaw = 1'b0;
      default:   takeRaw = 1'b0;
    endcase
  end

  assign taken  = takeRaw;
  assign nextPc = !takeRaw ? pcQ : ((opQ == OP_BRANCH) ? branchPc : skipPc);

  AST_COUNT_SKIP_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && wbEn) |-> (taken == (wbData == '0))); // R9

  AST_NOT_TAKEN_HOLDS_PC: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && !taken) |-> (nextPc == pcQ)); // R4

  AST_NOOP_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && opQ == OP_NONE) |-> (!taken && !wbEn)); // R12

endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
  import bsu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int DISP_W  = 8,
  parameter int NUM_EXT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [2:0]         opSel,
  input  logic [WIDTH-1:0]   pcIn,
  input  logic [WIDTH-1:0]   accIn,
  input  logic [WIDTH-1:0]   memIn,
  input  logic [DISP_W-1:0]  immIn,
  input  logic [3:0]         condCode,
  input  logic               carryIn,
  input  logic               ovfIn,
  input  logic               linkIn,
  input  logic [NUM_EXT-1:0] extCond,
  output logic               outValid,
  input  logic               outReady,
  output logic [WIDTH-1:0]   nextPc,
  output logic               taken,
  output logic               wbValid,
  output logic [WIDTH-1:0]   wbData
);

  ctrlStrobe_t strobe;
  logic        wbEn;

  bsu_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  bsu_datapath #(.WIDTH(WIDTH), .DISP_W(DISP_W), .NUM_EXT(NUM_EXT)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opIn   (opSel),
    .pcIn   (pcIn),
    .accIn  (accIn),
    .memIn  (memIn),
    .immIn  (immIn),
    .condIn (condCode),
    .carryIn(carryIn),
    .ovfIn  (ovfIn),
    .linkIn (linkIn),
    .extIn  (extCond),
    .nextPc (nextPc),
    .taken  (taken),
    .wbEn   (wbEn),
    .wbData (wbData)
  );

  assign wbValid = outValid && wbEn;

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(nextPc) && $stable(taken) && $stable(wbData))); // R2

  AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> outValid); // R12

endmodule

// File: tb/branch_skip_unit_test.sv
`timescale 1ns/1ps
module branch_skip_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [2:0]  opSel = '0;
  logic [15:0] pcIn = '0, accIn = '0, memIn = '0;
  logic [7:0]  immIn = '0;
  logic [3:0]  condCode = '0;
  logic        carryIn = 1'b0, ovfIn = 1'b0, linkIn = 1'b0;
  logic [2:0]  extCond = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [15:0] nextPc;
  logic        taken;
  logic        wbValid;
  logic [15:0] wbData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  branch_skip_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opSel(opSel), .pcIn(pcIn), .accIn(accIn), .memIn(memIn), .immIn(immIn),
    .condCode(condCode), .carryIn(carryIn), .ovfIn(ovfIn), .linkIn(linkIn),
    .extCond(extCond), .outValid(outValid), .outReady(outReady),
    .nextPc(nextPc), .taken(taken), .wbValid(wbValid), .wbData(wbData)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // condition model written from the R5 table
  function automatic bit condModel(input logic [3:0] cc, input logic [15:0] a,
                                   input bit c, input bit o, input bit l,
                                   input logic [2:0] e);
    case (cc)
      4'd0:  return 1'b1;
      4'd1:  return a == 16'h0000;
      4'd2:  return a[15];
      4'd3:  return a != 16'h0000;
      4'd4:  return c;
      4'd5:  return o;
      4'd6:  return l;
      4'd7:  return !a[15];
      4'd13: return e[0];
      4'd14: return e[1];
      4'd15: return e[2];
      default: return 1'b0;
    endcase
  endfunction

  // one full request/response exchange with a held-back response cycle
  task automatic runOp(input string req, input logic [2:0] op,
                       input logic [15:0] pc, input logic [15:0] acc,
                       input logic [15:0] mem, input logic [7:0] imm,
                       input logic [3:0] cc, input bit c, input bit o, input bit l,
                       input logic [2:0] e,
                       input logic [15:0] expPc, input bit expTake,
                       input bit expWb, input logic [15:0] expWbData);
    @(negedge clk);
    check("R1", "inReady idle", inReady, 1);
    opSel = op; pcIn = pc; accIn = acc; memIn = mem; immIn = imm;
    condCode = cc; carryIn = c; ovfIn = o; linkIn = l; extCond = e;
    inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check("R1", "outValid after accept", outValid, 1);
    check("R1", "inReady while busy", inReady, 0);
    check(req, "nextPc", nextPc, expPc);
    check(req, "taken", taken, expTake);
    check(req, "wbValid", wbValid, expWb);
    if (expWb) check(req, "wbData", wbData, expWbData);
    // disturb the request side while the result is held
    pcIn = ~pc; accIn = ~acc; memIn = ~mem; immIn = ~imm; condCode = ~cc;
    extCond = ~e; carryIn = !c; ovfIn = !o; linkIn = !l; opSel = ~op;
    @(negedge clk);
    check("R2", "outValid held", outValid, 1);
    check("R2", "nextPc held", nextPc, expPc);
    check("R2", "taken held", taken, expTake);
    check("R2", "wbValid held", wbValid, expWb);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check("R1", "outValid after release", outValid, 0);
    check("R1", "inReady after release", inReady, 1);
    check("R12", "wbValid idle", wbValid, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R13", "outValid in reset", outValid, 0);
    check("R13", "wbValid in reset", wbValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R13", "outValid after reset", outValid, 0);
    check("R1", "inReady after reset", inReady, 1);
  endtask

  task automatic testCondTable();
    for (int k = 0; k < 16; k++) begin
      bit t;
      t = condModel(4'(k), 16'h0000, 1'b1, 1'b0, 1'b1, 3'b101);
      runOp("R5", 3'd0, 16'h1000, 16'h0000, 16'h0, 8'h10, 4'(k), 1'b1, 1'b0, 1'b1,
            3'b101, t ? 16'h1010 : 16'h1000, t, 1'b0, 16'h0);
      t = condModel(4'(k), 16'h8001, 1'b0, 1'b1, 1'b0, 3'b010);
      runOp("R5", 3'd0, 16'h2000, 16'h8001, 16'h0, 8'hF0, 4'(k), 1'b0, 1'b1, 1'b0,
            3'b010, t ? 16'h1FF0 : 16'h2000, t, 1'b0, 16'h0);
    end
  endtask

  task automatic testBranchWrap();
    runOp("R3", 3'd0, 16'hFFF0, 16'h0, 16'h0, 8'h20, 4'd0, 0, 0, 0, 3'b0,
          16'h0010, 1'b1, 1'b0, 16'h0);
    runOp("R3", 3'd0, 16'h0005, 16'h0, 16'h0, 8'h80, 4'd0, 0, 0, 0, 3'b0,
          16'hFF85, 1'b1, 1'b0, 16'h0);
    runOp("R4", 3'd0, 16'h4321, 16'h0, 16'h0, 8'h7F, 4'd9, 1, 1, 1, 3'b111,
          16'h4321, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic testCompareSkips();
    runOp("R6", 3'd1, 16'h0100, 16'h1234, 16'h1235, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0101, 1'b1, 1'b0, 16'h0);
    runOp("R6", 3'd1, 16'h0100, 16'hBEEF, 16'hBEEF, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0100, 1'b0, 1'b0, 16'h0);
    runOp("R7", 3'd2, 16'h0200, 16'h8000, 16'h0001, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0200, 1'b0, 1'b0, 16'h0);
    runOp("R7", 3'd2, 16'h0200, 16'h0001, 16'hFFFF, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0201, 1'b1, 1'b0, 16'h0);
    runOp("R7", 3'd2, 16'h0200, 16'h7FFF, 16'h7FFF, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0200, 1'b0, 1'b0, 16'h0);
    runOp("R8", 3'd3, 16'h0300, 16'hF0F0, 16'h0F0F, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0301, 1'b1, 1'b0, 16'h0);
    runOp("R8", 3'd3, 16'h0300, 16'hF0F1, 16'h0F0F, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0300, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic testCountSkips();
    runOp("R9", 3'd4, 16'h0400, 16'h0, 16'hFFFF, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0401, 1'b1, 1'b1, 16'h0000);
    runOp("R9", 3'd4, 16'h0400, 16'h0, 16'h0041, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0400, 1'b0, 1'b1, 16'h0042);
    runOp("R9", 3'd5, 16'h0500, 16'h0, 16'h0001, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0501, 1'b1, 1'b1, 16'h0000);
    runOp("R9", 3'd5, 16'h0500, 16'h0, 16'h0000, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0500, 1'b0, 1'b1, 16'hFFFF);
    runOp("R10", 3'd6, 16'h0600, 16'h0005, 16'h0, 8'hFB, 4'd0, 0, 0, 0, 3'b0,
          16'h0601, 1'b1, 1'b1, 16'h0000);
    runOp("R10", 3'd6, 16'h0600, 16'h00F0, 16'h0, 8'h90, 4'd0, 0, 0, 0, 3'b0,
          16'h0600, 1'b0, 1'b1, 16'h0080);
  endtask

  task automatic testSkipWrapAndNoop();
    runOp("R11", 3'd1, 16'hFFFF, 16'h0001, 16'h0002, 8'h0, 4'd0, 0, 0, 0, 3'b0,
          16'h0000, 1'b1, 1'b0, 16'h0);
    runOp("R12", 3'd7, 16'h0777, 16'h0000, 16'hFFFF, 8'h01, 4'd0, 1, 1, 1, 3'b111,
          16'h0777, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    testReset();
    testCondTable();
    testBranchWrap();
    testCompareSkips();
    testCountSkips();
    testSkipWrapAndNoop();
    done = 1'b1;
    finishUp();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      finishUp();
    end
  end

endmodule